// File: doc/BRIEF.md
# Differential Block Write Unit for Non-Volatile Memory

This unit stands between a memory controller and a non-volatile cell array whose two programming directions cost different amounts of energy. A request carries one 512-bit block and its address. The unit reads the block that is stored at that address and compares it bit by bit with the incoming data. It then programs only the cells whose value changes, using a per-bit write mask. When nothing changes, no array write is issued at all.

Each changed bit falls into one of two classes. A bit that goes from 0 to 1 is a SET, which moves the cell to its low-resistance state. A bit that goes from 1 to 0 is a RESET, which moves it to its high-resistance state and costs more. The unit reports the count of each class and an integer energy score that weights a SET by 2 and a RESET by 3. This score tracks the roughly 1.5:1 cost ratio between the two pulses.

The array port is a plain synchronous read/write port. Read and program latencies are parameters counted in clock cycles, and the program window is much longer than the read window. Only one request is in flight at a time.

Top module: `rbw_write_unit`

## Requirements
- R1: While reset is held and just after it, req_ready is 1 and busy, done_valid, arr_rd_en and arr_wr_en are all 0.
- R2: After each accepted request, arr_rd_en is high for exactly RD_LAT consecutive cycles at the request address. arr_wr_en stays low during that window.
- R3: During programming, arr_wr_mask equals the stored block XOR the new block, and arr_wr_data equals the new block. After completion the array holds the new block, and other addresses are unchanged.
- R4: set_count equals the number of bit positions that are 0 in the stored block and 1 in the new block. reset_count equals the number of positions that are 1 in the stored block and 0 in the new block.
- R5: energy_score (12 bits) equals 2*set_count + 3*reset_count.
- R6: When the new block equals the stored block, arr_wr_en never rises for that request, and done_skipped is 1 on completion. Otherwise done_skipped is 0.
- R7: For a changed block, arr_wr_en is high for exactly PG_LAT consecutive cycles, with a mask that does not change.
- R8: busy rises in the cycle after acceptance and stays high until the completion cycle. req_ready is 0 while busy. A request offered while busy is neither accepted nor written.
- R9: done_valid is a single-cycle pulse. The result outputs hold their values after it until the next request reaches comparison.
- R10: When a block goes from all ones to all zeros, the unit reports 512 RESETs and energy 1536 with no overflow. When a block goes from all zeros to all ones, it reports 512 SETs and energy 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| req_data | input | BLOCK_W | New block contents |
| busy | output | 1 | A request is being processed |
| done_valid | output | 1 | One-cycle completion pulse |
| done_skipped | output | 1 | Completed request needed no array write |
| set_count | output | CNT_W | Number of 0-to-1 bits in the last request |
| reset_count | output | CNT_W | Number of 1-to-0 bits in the last request |
| energy_score | output | ENERGY_W | Weighted write-energy score |
| arr_addr | output | ADDR_W | Array address |
| arr_rd_en | output | 1 | Array read enable |
| arr_rd_data | input | BLOCK_W | Array read data, registered by the array |
| arr_wr_en | output | 1 | Array program enable |
| arr_wr_mask | output | BLOCK_W | Per-bit program mask |
| arr_wr_data | output | BLOCK_W | Program data |

## Verification
The checker watches several properties on every cycle. It confirms that read and program enables are never high together and that a program cycle never carries an empty mask. It also checks that the mask holds still through a program run, that each run lasts PG_LAT cycles, and that busy follows acceptance. It further checks that done_valid is a lone pulse and that the energy score agrees with the two counts. Other behaviours can only be shown by the bench's scenarios against its own array model. These are the correctness of the counts, the agreement of the mask with the actual stored contents, the skip decision for unchanged data, the final array contents, the refusal of a request offered mid-operation, and the saturated all-bits cases.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_COMPARE = 3'd2,
        ST_PROGRAM = 3'd3,
        ST_DONE    = 3'd4
    } rbw_state_e;
endpackage

// File: rtl/rbw_popcount.sv
module rbw_popcount #(
    parameter int W  = 512,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/rbw_bit_classify.sv
module rbw_bit_classify #(
    parameter int W  = 512,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  stored,
    input  logic [W-1:0]  incoming,
    output logic [W-1:0]  diff,
    output logic [CW-1:0] n_set,
    output logic [CW-1:0] n_reset,
    output logic          any_change
);
    logic [W-1:0] up_bits;
    logic [W-1:0] down_bits;

    // 0 -> 1 drives the cell to its low-resistance state, 1 -> 0 to high-resistance
    assign up_bits    = incoming & ~stored;
    assign down_bits  = stored & ~incoming;
    assign diff       = stored ^ incoming;
    assign any_change = |diff;

    rbw_popcount #(.W(W), .CW(CW)) u_cnt_up (
        .bits  (up_bits),
        .count (n_set)
    );

    rbw_popcount #(.W(W), .CW(CW)) u_cnt_down (
        .bits  (down_bits),
        .count (n_reset)
    );
endmodule

// File: rtl/rbw_cycle_timer.sv
module rbw_cycle_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rbw_write_unit.sv
module rbw_write_unit #(
    parameter int BLOCK_W  = 512,
    parameter int ADDR_W   = 20,
    parameter int RD_LAT   = 2,
    parameter int PG_LAT   = 20,
    parameter int SET_WT   = 2,
    parameter int RST_WT   = 3,
    parameter int ENERGY_W = 12,
    parameter int CNT_W    = $clog2(BLOCK_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BLOCK_W-1:0]  req_data,
    output logic                busy,
    output logic                done_valid,
    output logic                done_skipped,
    output logic [CNT_W-1:0]    set_count,
    output logic [CNT_W-1:0]    reset_count,
    output logic [ENERGY_W-1:0] energy_score,
    output logic [ADDR_W-1:0]   arr_addr,
    output logic                arr_rd_en,
    input  logic [BLOCK_W-1:0]  arr_rd_data,
    output logic                arr_wr_en,
    output logic [BLOCK_W-1:0]  arr_wr_mask,
    output logic [BLOCK_W-1:0]  arr_wr_data
);
    import rbw_pkg::*;

    localparam int TMAX = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        rbw_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic [BLOCK_W-1:0]  wdata;
        logic [BLOCK_W-1:0]  diff;
        logic [CNT_W-1:0]    n_set;
        logic [CNT_W-1:0]    n_reset;
        logic [ENERGY_W-1:0] energy;
        logic                skipped;
    } rbw_regs_t;

    rbw_regs_t r_d, r_q;

    logic [BLOCK_W-1:0] cls_diff;
    logic [CNT_W-1:0]   cls_set;
    logic [CNT_W-1:0]   cls_reset;
    logic               cls_any;
    logic               tm_load;
    logic [TW-1:0]      tm_val;
    logic               tm_expired;

    rbw_bit_classify #(.W(BLOCK_W), .CW(CNT_W)) u_classify (
        .stored     (arr_rd_data),
        .incoming   (r_q.wdata),
        .diff       (cls_diff),
        .n_set      (cls_set),
        .n_reset    (cls_reset),
        .any_change (cls_any)
    );

    rbw_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_expired)
    );

    always_comb begin
        r_d     = r_q;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_READ;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_data;
                    tm_load   = 1'b1;
                    tm_val    = TW'(RD_LAT - 1);
                end
            end
            ST_READ: begin
                if (tm_expired) r_d.state = ST_COMPARE;
            end
            ST_COMPARE: begin
                r_d.diff    = cls_diff;
                r_d.n_set   = cls_set;
                r_d.n_reset = cls_reset;
                r_d.energy  = ENERGY_W'(cls_set) * ENERGY_W'(SET_WT)
                            + ENERGY_W'(cls_reset) * ENERGY_W'(RST_WT);
                r_d.skipped = !cls_any;
                if (cls_any) begin
                    r_d.state = ST_PROGRAM;
                    tm_load   = 1'b1;
                    tm_val    = TW'(PG_LAT - 1);
                end else begin
                    r_d.state = ST_DONE;
                end
            end
            ST_PROGRAM: begin
                if (tm_expired) r_d.state = ST_DONE;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.addr    <= '0;
            r_q.wdata   <= '0;
            r_q.diff    <= '0;
            r_q.n_set   <= '0;
            r_q.n_reset <= '0;
            r_q.energy  <= '0;
            r_q.skipped <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.state == ST_IDLE);
    assign busy         = (r_q.state != ST_IDLE);
    assign done_valid   = (r_q.state == ST_DONE);
    assign done_skipped = r_q.skipped;
    assign set_count    = r_q.n_set;
    assign reset_count  = r_q.n_reset;
    assign energy_score = r_q.energy;
    assign arr_addr     = r_q.addr;
    assign arr_rd_en    = (r_q.state == ST_READ);
    assign arr_wr_en    = (r_q.state == ST_PROGRAM);
    assign arr_wr_mask  = (r_q.state == ST_PROGRAM) ? r_q.diff : '0;
    assign arr_wr_data  = r_q.wdata;
endmodule

module rbw_write_unit_checker #(
    parameter int BLOCK_W  = 512,
    parameter int PG_LAT   = 20,
    parameter int CNT_W    = 10,
    parameter int ENERGY_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                busy,
    input logic                done_valid,
    input logic                done_skipped,
    input logic [CNT_W-1:0]    set_count,
    input logic [CNT_W-1:0]    reset_count,
    input logic [ENERGY_W-1:0] energy_score,
    input logic                arr_rd_en,
    input logic                arr_wr_en,
    input logic [BLOCK_W-1:0]  arr_wr_mask
);
    logic [15:0] wr_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wr_run_q <= '0;
        else if (arr_wr_en) wr_run_q <= wr_run_q + 16'd1;
        else                wr_run_q <= '0;
    end

    assert_no_rd_wr_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && arr_wr_en));

    assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (arr_wr_mask != '0));

    assert_mask_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && $past(arr_wr_en)) |-> $stable(arr_wr_mask));

    assert_program_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_wr_en && wr_run_q != '0) |-> (wr_run_q == 16'(PG_LAT)));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_energy_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (energy_score == ENERGY_W'(set_count) * ENERGY_W'(2)
                                       + ENERGY_W'(reset_count) * ENERGY_W'(3)));

    assert_skip_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_skipped) |-> (set_count == '0 && reset_count == '0));
endmodule

bind rbw_write_unit rbw_write_unit_checker #(
    .BLOCK_W  (BLOCK_W),
    .PG_LAT   (PG_LAT),
    .CNT_W    (CNT_W),
    .ENERGY_W (ENERGY_W)
) u_rbw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .busy         (busy),
    .done_valid   (done_valid),
    .done_skipped (done_skipped),
    .set_count    (set_count),
    .reset_count  (reset_count),
    .energy_score (energy_score),
    .arr_rd_en    (arr_rd_en),
    .arr_wr_en    (arr_wr_en),
    .arr_wr_mask  (arr_wr_mask)
);

// File: tb/rbw_write_unit_bench.sv
module rbw_write_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BW     = 512;
    localparam int AW     = 4;
    localparam int RDL    = 3;
    localparam int PGL    = 5;
    localparam int CW     = 10;
    localparam int EW     = 12;
    localparam int NVEC   = 8;

    // kind: 0 all zeros, 1 all ones, 2 seeded pattern, 3 repeat stored block
    localparam logic [AW-1:0] T_ADDR [NVEC] = '{4'd1, 4'd1, 4'd2, 4'd2, 4'd2, 4'd3, 4'd3, 4'd1};
    localparam logic [1:0]    T_KIND [NVEC] = '{2'd1, 2'd0, 2'd2, 2'd3, 2'd2, 2'd2, 2'd2, 2'd0};
    localparam logic [31:0]   T_SEED [NVEC] = '{32'h0, 32'h0, 32'hA5A50F0F, 32'h0,
                                                32'h5A5AF0F0, 32'h00000001, 32'h80000001, 32'h0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_data = '0;
    logic          busy, done_valid, done_skipped;
    logic [CW-1:0] set_count, reset_count;
    logic [EW-1:0] energy_score;
    logic [AW-1:0] arr_addr;
    logic          arr_rd_en, arr_wr_en;
    logic [BW-1:0] arr_rd_data, arr_wr_mask, arr_wr_data;
    logic [BW-1:0] mem [16];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbw_write_unit #(.BLOCK_W(BW), .ADDR_W(AW), .RD_LAT(RDL), .PG_LAT(PGL), .ENERGY_W(EW)) u_rbw_write_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done_valid(done_valid),
        .done_skipped(done_skipped), .set_count(set_count), .reset_count(reset_count),
        .energy_score(energy_score), .arr_addr(arr_addr), .arr_rd_en(arr_rd_en),
        .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_mask(arr_wr_mask),
        .arr_wr_data(arr_wr_data)
    );

    // array model: registered read, masked write
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            arr_rd_data <= '0;
        end else begin
            if (arr_rd_en) arr_rd_data <= mem[arr_addr];
            if (arr_wr_en) mem[arr_addr] <= (mem[arr_addr] & ~arr_wr_mask) | (arr_wr_data & arr_wr_mask);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] make_block(input logic [1:0] kind, input logic [31:0] seed,
                                                 input logic [BW-1:0] cur);
        logic [BW-1:0] b;
        case (kind)
            2'd0: b = '0;
            2'd1: b = '1;
            2'd3: b = cur;
            default: for (int k = 0; k < BW/32; k++) b[k*32 +: 32] = seed ^ (32'h01010101 * k);
        endcase
        return b;
    endfunction

    task automatic run_write(input logic [AW-1:0] a, input logic [BW-1:0] d, input bit intrude);
        logic [BW-1:0] old_v, other_v, exp_mask;
        int es, er, rd_cyc, wr_cyc, guard, mask_bad, overlap, busy_bad, ready_bad;
        logic [CW-1:0] held_set;
        old_v   = mem[a];
        other_v = mem[a ^ 4'd8];
        exp_mask = old_v ^ d;
        es = 0; er = 0;
        for (int i = 0; i < BW; i++) begin
            if (!old_v[i] && d[i]) es++;
            if (old_v[i] && !d[i]) er++;
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        rd_cyc = 0; wr_cyc = 0; guard = 0; mask_bad = 0; overlap = 0; busy_bad = 0; ready_bad = 0;
        if (intrude) begin
            req_addr = a ^ 4'd8; req_data = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (!done_valid && guard < 200) begin
            if (!busy) busy_bad++;
            if (req_ready) ready_bad++;
            if (arr_rd_en) begin
                rd_cyc++;
                if (arr_addr != a) mask_bad++;
            end
            if (arr_wr_en) begin
                wr_cyc++;
                if (arr_wr_mask != exp_mask || arr_wr_data != d) mask_bad++;
            end
            if (arr_rd_en && wr_cyc != 0) overlap++;
            guard++;
            @(negedge clk);
            if (guard == 4 && intrude) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        chk(done_valid, "R9 done seen", done_valid, 1);
        chk(busy_bad == 0, "R8 busy held", busy_bad, 0);
        chk(ready_bad == 0, "R8 ready low while busy", ready_bad, 0);
        chk(rd_cyc == RDL, "R2 read cycles", rd_cyc, RDL);
        chk(overlap == 0, "R2 read before program", overlap, 0);
        chk(mask_bad == 0, "R3 mask and data", mask_bad, 0);
        chk(set_count == CW'(es), "R4 set count", set_count, es);
        chk(reset_count == CW'(er), "R4 reset count", reset_count, er);
        chk(energy_score == EW'(2*es + 3*er), "R5 energy", energy_score, 2*es + 3*er);
        chk(done_skipped == (es + er == 0), "R6 skip flag", done_skipped, (es + er == 0));
        chk(wr_cyc == ((es + er == 0) ? 0 : PGL), "R7 program cycles", wr_cyc, (es + er == 0) ? 0 : PGL);
        held_set = set_count;
        @(negedge clk);
        chk(!done_valid, "R9 single pulse", done_valid, 0);
        repeat (2) @(negedge clk);
        chk(set_count == held_set, "R9 results held", set_count, held_set);
        chk(mem[a] == d, "R3 array updated", mem[a] == d, 1);
        chk(mem[a ^ 4'd8] == other_v, "R8 other address untouched", mem[a ^ 4'd8] == other_v, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !busy && !done_valid && !arr_rd_en && !arr_wr_en,
            "R1 reset outputs", {req_ready, busy, done_valid, arr_rd_en, arr_wr_en}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy, "R1 idle after reset", {req_ready, busy}, 2'b10);

        for (int v = 0; v < NVEC; v++) begin
            run_write(T_ADDR[v], make_block(T_KIND[v], T_SEED[v], mem[T_ADDR[v]]), 1'b0);
        end

        // R10 extremes checked explicitly
        run_write(4'd5, '1, 1'b0);
        chk(set_count == CW'(512) && energy_score == EW'(1024), "R10 all set", energy_score, 1024);
        run_write(4'd5, '0, 1'b0);
        chk(reset_count == CW'(512) && energy_score == EW'(1536), "R10 all reset", energy_score, 1536);

        // R8 request offered while busy is refused
        run_write(4'd6, {16{32'hC3C3_1234}}, 1'b1);
        // R6 unchanged data after an intrusion attempt
        run_write(4'd6, {16{32'hC3C3_1234}}, 1'b0);
        // single-bit change at the top bit
        run_write(4'd7, {1'b1, {(BW-1){1'b0}}}, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule